// File: doc/BRIEF.md
# Wide-Bus Pipelined CRC-32 Engine

This block computes a 32-bit cyclic redundancy check over a message that arrives as whole 64-bit words, at up to one word per clock. The update is split into two linear parts. The first is the checksum contribution of the incoming word taken on its own, starting from a zero register. It has no feedback, so it is built as a two-stage pipeline of registered XOR networks. The second is the running register advanced across 64 zero bits. That is a fixed 32-by-32 matrix, and it sits in the feedback loop together with one final XOR. The loop therefore stays about as shallow as in a 32-bit-wide engine.

A message begins with a restart pulse. The word flagged as final closes the message, and the complemented checksum is then shown for one clock. A small controller with three states owns the checksum register. ST_IDLE waits for a restart. A restart in any state moves to ST_ACCUM and reloads the register with all ones. ST_ACCUM folds every pipelined word term into the register, and the arrival of the final word's term moves it to ST_FINISH. ST_FINISH presents the result for one cycle and then returns to ST_IDLE.

Top module: `crc32_wide_pipe`

## Requirements
- R1: While reset is asserted and after its release, `crc_valid` is 0 and `crc_out` is 0 until a message completes.
- R2: The checksum is the reflected CRC-32 with generator 0x04C11DB7 (shift-right constant 0xEDB88320), register preset to 0xFFFFFFFF and result complemented. Byte j of a word is `in_data[8j+7:8j]`, and byte 0 comes first. Within a byte, bit 0 is processed first.
- R3: For a message of N words (N ≥ 1), `crc_out` equals the checksum over all 8N bytes in arrival order.
- R4: Cycles with `in_valid` low between the words of a message do not change the result, whatever `in_data` and `in_last` hold during those cycles.
- R5: If the word flagged by `in_last` is sampled on rising edge k, `crc_valid` is 1 from edge k+2 to edge k+3, and is 0 on the two cycles before that and on the cycle after.
- R6: A restart pulse reloads the register to all ones and discards every word still in the pipeline. A valid word sampled together with the restart is the first word of the new message.
- R7: Valid words, including ones with `in_last` set, that arrive outside a message never raise `crc_valid`. This covers words after a result and before the next restart.
- R8: `crc_out` is 0 in every cycle where `crc_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| init | input | 1 | Restart pulse that opens a new message |
| in_valid | input | 1 | Qualifies `in_data` and `in_last` |
| in_data | input | 64 | Message word, byte 0 in bits 7:0 |
| in_last | input | 1 | Marks the final word of the message |
| crc_valid | output | 1 | One-cycle strobe marking the result |
| crc_out | output | 32 | Complemented checksum while `crc_valid` is 1, else 0 |

## Verification
Stray words left in the pipeline when a restart arrives are targeted directly. One stray word sits in each of the two stages at that moment. A design that does not flush both stages, or that lets an absorbing term win over the reload, returns the checksum with junk mixed in. Random idle gaps with garbage on the data and last lines catch a state term applied on empty cycles or a last flag taken without its valid. Either fault would corrupt results or produce early strobes. Every message also checks the exact strobe cycle, so a skewed pipeline that meets the register one cycle off shows up as a latency error. Final-flagged words sent with no open message must stay silent.

// File: rtl/crc32_wide_pkg.sv
`timescale 1ns/1ps
package crc32_wide_pkg;

    localparam int CRC_W  = 32;
    localparam int MAX_DW = 256;

    localparam logic [CRC_W-1:0] POLY_REFL  = 32'hEDB88320;
    localparam logic [CRC_W-1:0] CRC_SEED   = 32'hFFFFFFFF;
    localparam logic [CRC_W-1:0] CRC_XOROUT = 32'hFFFFFFFF;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCUM  = 2'd1,
        ST_FINISH = 2'd2
    } crc_state_e;

    // Bit-serial advance over nbits of d, bit 0 first (used only for constants)
    function automatic logic [CRC_W-1:0] crc_shift(input logic [CRC_W-1:0] c_in,
                                                    input logic [MAX_DW-1:0] d,
                                                    input int nbits);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = c_in;
        for (int i = 0; i < MAX_DW; i++) begin
            if (i < nbits) begin
                fb = c[0] ^ d[i];
                c  = {1'b0, c[CRC_W-1:1]};
                if (fb) c = c ^ POLY_REFL;
            end
        end
        return c;
    endfunction

    // Contribution of a single set data bit, starting from a zero register
    function automatic logic [CRC_W-1:0] data_col(input int idx, input int nbits);
        logic [MAX_DW-1:0] one;
        one = {{(MAX_DW-1){1'b0}}, 1'b1} << idx;
        return crc_shift('0, one, nbits);
    endfunction

    // Register bit idx advanced across nbits zero data bits
    function automatic logic [CRC_W-1:0] state_col(input int idx, input int nbits);
        logic [CRC_W-1:0] e;
        e = {{(CRC_W-1){1'b0}}, 1'b1} << idx;
        return crc_shift(e, '0, nbits);
    endfunction

endpackage

// File: rtl/crc32_data_term.sv
`timescale 1ns/1ps
module crc32_data_term
    import crc32_wide_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SEG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [DATA_W-1:0] in_data,
    output logic              term_valid,
    output logic              term_last,
    output logic [CRC_W-1:0]  term
);

    localparam int NSEG = DATA_W / SEG_W;

    function automatic logic [DATA_W-1:0][CRC_W-1:0] build_cols();
        logic [DATA_W-1:0][CRC_W-1:0] t;
        for (int i = 0; i < DATA_W; i++) t[i] = data_col(i, DATA_W);
        return t;
    endfunction

    localparam logic [DATA_W-1:0][CRC_W-1:0] COLS = build_cols();

    logic [NSEG-1:0][CRC_W-1:0] seg_d;
    logic [NSEG-1:0][CRC_W-1:0] seg_q;
    logic                       v1_q, last1_q;
    logic [CRC_W-1:0]           term_d;

    // Stage 1: partial sums, one per data segment
    always_comb begin
        seg_d = '0;
        for (int s = 0; s < NSEG; s++) begin
            for (int b = 0; b < SEG_W; b++) begin
                if (in_data[s*SEG_W + b]) seg_d[s] = seg_d[s] ^ COLS[s*SEG_W + b];
            end
        end
    end

    // Stage 2: fold the segment sums
    always_comb begin
        term_d = '0;
        for (int s = 0; s < NSEG; s++) term_d = term_d ^ seg_q[s];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q      <= '0;
            v1_q       <= 1'b0;
            last1_q    <= 1'b0;
            term       <= '0;
            term_valid <= 1'b0;
            term_last  <= 1'b0;
        end else begin
            seg_q      <= seg_d;
            v1_q       <= in_valid;
            last1_q    <= in_last;
            term       <= term_d;
            term_valid <= flush ? 1'b0 : v1_q;
            term_last  <= last1_q;
        end
    end

endmodule

// File: rtl/crc32_state_term.sv
`timescale 1ns/1ps
module crc32_state_term
    import crc32_wide_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [CRC_W-1:0] crc_q,
    output logic [CRC_W-1:0] advanced
);

    function automatic logic [CRC_W-1:0][CRC_W-1:0] build_cols();
        logic [CRC_W-1:0][CRC_W-1:0] t;
        for (int j = 0; j < CRC_W; j++) t[j] = state_col(j, DATA_W);
        return t;
    endfunction

    localparam logic [CRC_W-1:0][CRC_W-1:0] SCOLS = build_cols();

    // Each output bit is an XOR of at most CRC_W register bits
    always_comb begin
        advanced = '0;
        for (int j = 0; j < CRC_W; j++) begin
            if (crc_q[j]) advanced = advanced ^ SCOLS[j];
        end
    end

endmodule

// File: rtl/crc32_ctrl.sv
`timescale 1ns/1ps
module crc32_ctrl
    import crc32_wide_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             term_valid,
    input  logic             term_last,
    input  logic [CRC_W-1:0] data_term,
    input  logic [CRC_W-1:0] state_term,
    output logic [CRC_W-1:0] crc_q,
    output logic             crc_valid,
    output logic [CRC_W-1:0] crc_out
);

    crc_state_e       state_q, state_d;
    logic [CRC_W-1:0] crc_d;
    logic             absorb;

    assign absorb = (state_q == ST_ACCUM) && term_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (init) begin
            state_d = ST_ACCUM;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_ACCUM:  if (term_valid && term_last) state_d = ST_FINISH;
                ST_FINISH: state_d = ST_IDLE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        crc_d = crc_q;
        if (init)        crc_d = CRC_SEED;
        else if (absorb) crc_d = state_term ^ data_term;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= CRC_SEED;
        else        crc_q <= crc_d;
    end

    always_comb begin
        crc_valid = 1'b0;
        crc_out   = '0;
        unique case (state_q)
            ST_FINISH: begin
                crc_valid = 1'b1;
                crc_out   = crc_q ^ CRC_XOROUT;
            end
            default: begin
                crc_valid = 1'b0;
                crc_out   = '0;
            end
        endcase
    end

endmodule

// File: rtl/crc32_wide_pipe.sv
`timescale 1ns/1ps
module crc32_wide_pipe
    import crc32_wide_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SEG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              crc_valid,
    output logic [CRC_W-1:0]  crc_out
);

    logic             term_valid, term_last;
    logic [CRC_W-1:0] data_term, state_term, crc_q;

    crc32_data_term #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (init),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .in_data    (in_data),
        .term_valid (term_valid),
        .term_last  (term_last),
        .term       (data_term)
    );

    crc32_state_term #(.DATA_W(DATA_W)) u_state (
        .crc_q    (crc_q),
        .advanced (state_term)
    );

    crc32_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .init       (init),
        .term_valid (term_valid),
        .term_last  (term_last),
        .data_term  (data_term),
        .state_term (state_term),
        .crc_q      (crc_q),
        .crc_valid  (crc_valid),
        .crc_out    (crc_out)
    );

endmodule

// File: rtl/crc32_wide_chk.sv
`timescale 1ns/1ps
module crc32_wide_chk
    import crc32_wide_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             init,
    input logic             in_valid,
    input logic             in_last,
    input logic             crc_valid,
    input logic [CRC_W-1:0] crc_out
);

    // R5
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_valid |=> !crc_valid);

    // R5
    strobe_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_valid |-> $past(in_valid && in_last, 3));

    // R6
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> !crc_valid);

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !crc_valid |-> (crc_out == '0));

endmodule

bind crc32_wide_pipe crc32_wide_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .init      (init),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .crc_valid (crc_valid),
    .crc_out   (crc_out)
);

// File: tb/crc32_wide_pipe_tb.sv
`timescale 1ns/1ps
module crc32_wide_pipe_tb;

    localparam realtime CLK_PERIOD = 8ns;

    logic        clk = 1'b0;
    logic        rst_n, init, in_valid, in_last;
    logic [63:0] in_data;
    logic        crc_valid;
    logic [31:0] crc_out;

    int n_checks = 0;
    int n_errors = 0;
    logic [63:0] msg [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    crc32_wide_pipe u_dut (
        .clk(clk), .rst_n(rst_n), .init(init), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .crc_valid(crc_valid), .crc_out(crc_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    // Bit-serial reference, R2 ordering
    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] c = 32'hFFFFFFFF;
        logic fb;
        for (int w = 0; w < n; w++) begin
            for (int b = 0; b < 64; b++) begin
                fb = c[0] ^ msg[w][b];
                c  = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return ~c;
    endfunction

    task automatic idle_inputs();
        init = 1'b0; in_valid = 1'b0; in_last = 1'($urandom_range(1, 0));
        in_data = {$urandom(), $urandom()};
    endtask

    task automatic send_msg(input int n, input int maxgap, input bit init_first, input string tag);
        logic [31:0] exp;
        exp = ref_crc(n);
        if (!init_first) begin
            init = 1'b1;
            @(negedge clk);
            idle_inputs();
        end
        for (int w = 0; w < n; w++) begin
            in_valid = 1'b1; in_data = msg[w]; in_last = (w == n-1);
            init = init_first && (w == 0);
            @(negedge clk);
            idle_inputs();
            if (w != n-1 && maxgap > 0) repeat ($urandom_range(maxgap, 0)) begin
                @(negedge clk);
                idle_inputs();
            end
        end
        check("R5 strobe k+1", {31'd0, crc_valid}, 32'd0);
        @(negedge clk);
        check("R5 strobe k+2", {31'd0, crc_valid}, 32'd0);
        @(negedge clk);
        check("R5 strobe at result", {31'd0, crc_valid}, 32'd1);
        check(tag, crc_out, exp);
        @(negedge clk);
        check("R5 strobe after", {31'd0, crc_valid}, 32'd0);
        check("R8 output zero", crc_out, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_C0DE));
        rst_n = 1'b0; init = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = '0;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {31'd0, crc_valid}, 32'd0);
        check("R1 out in reset", crc_out, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", {31'd0, crc_valid}, 32'd0);
        check("R8 out after reset", crc_out, 32'd0);

        // R2: ASCII "12345678" as one word
        msg[0] = 64'h3837363534333231;
        send_msg(1, 0, 1'b1, "R2 ascii word");

        // R3: two words with a separate restart
        msg[0] = 64'h0123456789ABCDEF; msg[1] = 64'hFFFFFFFF00000000;
        send_msg(2, 0, 1'b0, "R3 two words");

        // R4: same message, no gaps then wide gaps
        for (int i = 0; i < 6; i++) msg[i] = {$urandom(), $urandom()};
        send_msg(6, 0, 1'b1, "R4 no gaps");
        send_msg(6, 5, 1'b1, "R4 with gaps");

        // R6: stray words in both pipeline stages when the restart arrives
        init = 1'b1; @(negedge clk);
        init = 1'b0; in_valid = 1'b1; in_last = 1'b0; in_data = 64'hDEADBEEFCAFEF00D;
        @(negedge clk);
        in_data = 64'h5555AAAA5555AAAA;
        @(negedge clk);
        for (int i = 0; i < 3; i++) msg[i] = {$urandom(), $urandom()};
        send_msg(3, 0, 1'b1, "R6 flushed restart");

        // R7: final-flagged words with no open message
        for (int i = 0; i < 3; i++) begin
            in_valid = 1'b1; in_last = 1'b1; in_data = {$urandom(), $urandom()};
            @(negedge clk);
        end
        idle_inputs();
        for (int i = 0; i < 5; i++) begin
            check("R7 no strobe", {31'd0, crc_valid}, 32'd0);
            check("R8 out quiet", crc_out, 32'd0);
            @(negedge clk);
        end

        // R3/R4/R5: random lengths, gaps and restart styles
        for (int m = 0; m < 30; m++) begin
            int n;
            n = $urandom_range(16, 1);
            for (int i = 0; i < n; i++) msg[i] = {$urandom(), $urandom()};
            send_msg(n, $urandom_range(3, 0), 1'($urandom_range(1, 0)), "R3 random message");
        end

        summary();
        $finish;
    end

endmodule